// File: doc/BRIEF.md
# Multiply and Extension-Register Execution Unit

This unit executes a small group of data-register operations for a 32-bit processor. It has signed and unsigned 32x32 multiplies. The low product word goes to the destination register and the high word goes to a dedicated extension register held inside the unit. The unit also moves values into and out of that extension register, clamps a signed value to a 16-bit or 24-bit range, and tests whether a value shifted left is still nonzero.

The decode stage presents one operation per cycle. Each operation carries an operation code, two register operands and an optional immediate with its size class, together with the current status flags. Exactly one clock edge later the unit presents three results: a registered destination write (enable and data), the updated extension register, and the updated flags. Fetch, full opcode decode, the register file and memory are outside the block.

Top module: `mulx_exec_unit`

## Requirements
- R1: With `op_valid` high and `op_code` 0 (signed multiply), `src_a` and the second operand are treated as signed. The 64-bit product's bits 31:0 appear on `dst_data` with `dst_we` high, and bits 63:32 appear on `xr_q`.
- R2: With `op_code` 1 (unsigned multiply), the product is split in the same way, but both operands are treated as unsigned.
- R3: After either multiply, `flags_out` (ordered {V,C,N,Z}) has Z set when the low word is zero, N equal to bit 31 of the low word, and C and V cleared.
- R4: `imm_sel` picks the second operand: 0 uses `src_b`, 1 uses `imm_hi[7:0]` sign-extended, 2 uses `imm_hi` sign-extended, and 3 uses {`imm_hi`,`imm_lo`}. An immediate is sign-extended for the unsigned multiply as well.
- R5: With `op_code` 2 (extension write), `xr_q` takes the value of `src_b`, `dst_we` stays low and `flags_out` equals `flags_in`.
- R6: With `op_code` 3 (extension read), `dst_data` takes the old `xr_q` with `dst_we` high. Z is set when that value is zero, N is bit 31, and C and V are cleared.
- R7: With `op_code` 4, `dst_data` is `src_b` clamped to the range -32768 to 32767, and `flags_out` equals `flags_in`.
- R8: With `op_code` 5, `dst_data` is `src_b` clamped to the range -8388608 to 8388607, and `flags_out` equals `flags_in`.
- R9: With `op_code` 6 (bit test), C becomes 1 when `src_b` shifted left by `src_a[4:0]` and truncated to 32 bits is nonzero. V, N and Z are copied from `flags_in`, and `dst_we` stays low.
- R10: Every operation completes on the first clock edge after it is presented, and the destination write and the extension write of a multiply take effect on that same edge. With `op_valid` low, `dst_we` is low and `xr_q` and `flags_out` hold their values.
- R11: During and after reset, `dst_we` is 0, `dst_data` is 0, `xr_q` is 0 and `flags_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | Operation selector (0..6, 7 = no-op) |
| src_a | input | 32 | First operand: multiplicand, or the shift count for the bit test |
| src_b | input | 32 | Second operand register value |
| imm_sel | input | 2 | Second-operand source and immediate size class |
| imm_hi | input | 16 | Immediate field; upper half for the 32-bit immediate |
| imm_lo | input | 16 | Extension field; lower half for the 32-bit immediate |
| flags_in | input | 4 | Current flags {V,C,N,Z} |
| dst_we | output | 1 | Destination register write enable |
| dst_data | output | 32 | Destination register write data |
| xr_q | output | 32 | Extension register contents |
| flags_out | output | 4 | Updated flags {V,C,N,Z} |

## Verification
On every cycle, the assertions check the flag pattern of each operation class and the range of each saturated result. They also check that an extension write and an extension read move the right value between `src_b`, `xr_q` and `dst_data`, and that an idle cycle disturbs nothing. The exact product split, the signedness of each multiply, the sign extension of the immediates, and the clamp values at and beyond each bound can only be shown by the bench's directed scenarios. The same holds for the shift count taking only its low five bits.

// File: rtl/mulx_pkg.sv
package mulx_pkg;
  typedef enum logic [2:0] {
    OP_MULS    = 3'd0,
    OP_MULU    = 3'd1,
    OP_XR_PUT  = 3'd2,
    OP_XR_GET  = 3'd3,
    OP_SAT_LO  = 3'd4,
    OP_SAT_HI  = 3'd5,
    OP_BITTEST = 3'd6,
    OP_NOP     = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    IMM_NONE = 2'd0,
    IMM_B8   = 2'd1,
    IMM_B16  = 2'd2,
    IMM_B32  = 2'd3
  } imm_e;

  typedef struct packed {
    logic v;
    logic c;
    logic n;
    logic z;
  } flags_t;
endpackage

// File: rtl/mulx_operand_sel.sv
module mulx_operand_sel #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]   src_b,
  input  logic [1:0]      imm_sel,
  input  logic [DW/2-1:0] imm_hi,
  input  logic [DW/2-1:0] imm_lo,
  output logic [DW-1:0]   operand
);
  import mulx_pkg::*;
  localparam int HW = DW / 2;

  function automatic logic [DW-1:0] sext8(input logic [7:0] v);
    return {{(DW-8){v[7]}}, v};
  endfunction

  function automatic logic [DW-1:0] sext_half(input logic [HW-1:0] v);
    return {{(DW-HW){v[HW-1]}}, v};
  endfunction

  always_comb begin
    unique case (imm_e'(imm_sel))
      IMM_B8:  operand = sext8(imm_hi[7:0]);
      IMM_B16: operand = sext_half(imm_hi);
      IMM_B32: operand = {imm_hi, imm_lo};
      default: operand = src_b;
    endcase
  end
endmodule

// File: rtl/mulx_multiplier.sv
module mulx_multiplier #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]   mcand,
  input  logic [DW-1:0]   mplier,
  input  logic            is_signed,
  output logic [2*DW-1:0] product
);
  logic signed [DW:0]     a_ext;
  logic signed [DW:0]     b_ext;
  logic signed [2*DW+1:0] full;

  // One extra top bit per operand lets a single signed array serve both modes.
  always_comb begin
    a_ext   = $signed({is_signed & mcand[DW-1], mcand});
    b_ext   = $signed({is_signed & mplier[DW-1], mplier});
    full    = a_ext * b_ext;
    product = full[2*DW-1:0];
  end
endmodule

// File: rtl/mulx_saturate.sv
module mulx_saturate #(
  parameter int DW = 32,
  parameter int SW = 16
) (
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          clipped
);
  localparam logic [DW-1:0] SAT_MAX = {{(DW-SW+1){1'b0}}, {(SW-1){1'b1}}};
  localparam logic [DW-1:0] SAT_MIN = {{(DW-SW+1){1'b1}}, {(SW-1){1'b0}}};

  logic over_hi;
  logic under_lo;

  always_comb begin
    over_hi  = $signed(din) > $signed(SAT_MAX);
    under_lo = $signed(din) < $signed(SAT_MIN);
    clipped  = over_hi | under_lo;
    if (over_hi)       dout = SAT_MAX;
    else if (under_lo) dout = SAT_MIN;
    else               dout = din;
  end
endmodule

// File: rtl/mulx_exec_unit.sv
module mulx_exec_unit #(
  parameter int DW       = 32,
  parameter int SAT_W_LO = 16,
  parameter int SAT_W_HI = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [2:0]      op_code,
  input  logic [DW-1:0]   src_a,
  input  logic [DW-1:0]   src_b,
  input  logic [1:0]      imm_sel,
  input  logic [DW/2-1:0] imm_hi,
  input  logic [DW/2-1:0] imm_lo,
  input  logic [3:0]      flags_in,
  output logic            dst_we,
  output logic [DW-1:0]   dst_data,
  output logic [DW-1:0]   xr_q,
  output logic [3:0]      flags_out
);
  import mulx_pkg::*;
  localparam int SHW   = $clog2(DW);
  localparam int N_SAT = 2;

  op_e             op;
  flags_t          f_in;
  flags_t          f_next;
  logic [DW-1:0]   operand;
  logic [2*DW-1:0] product;
  logic [DW-1:0]   sat_res [N_SAT];
  logic [N_SAT-1:0] sat_clip;
  logic            bit_hit;
  logic [DW-1:0]   dst_next;
  logic [DW-1:0]   xr_next;

  // Named events, observed by the bound checker.
  logic ev_mul, ev_xr_put, ev_xr_get, ev_sat, ev_bittest;
  logic ev_dst_wr, ev_xr_wr;

  assign op   = op_e'(op_code);
  assign f_in = flags_t'(flags_in);

  function automatic logic shifted_nonzero(input logic [DW-1:0] v,
                                           input logic [SHW-1:0] amt);
    return (v << amt) != '0;
  endfunction

  function automatic flags_t result_flags(input logic [DW-1:0] r);
    flags_t f;
    f.v = 1'b0;
    f.c = 1'b0;
    f.n = r[DW-1];
    f.z = (r == '0);
    return f;
  endfunction

  mulx_operand_sel #(.DW(DW)) u_opsel (
    .src_b   (src_b),
    .imm_sel (imm_sel),
    .imm_hi  (imm_hi),
    .imm_lo  (imm_lo),
    .operand (operand)
  );

  mulx_multiplier #(.DW(DW)) u_mul (
    .mcand     (src_a),
    .mplier    (operand),
    .is_signed (op == OP_MULS),
    .product   (product)
  );

  for (genvar gi = 0; gi < N_SAT; gi++) begin : g_sat
    localparam int SW = (gi == 0) ? SAT_W_LO : SAT_W_HI;
    mulx_saturate #(.DW(DW), .SW(SW)) u_sat (
      .din     (src_b),
      .dout    (sat_res[gi]),
      .clipped (sat_clip[gi])
    );
  end

  assign bit_hit = shifted_nonzero(src_b, src_a[SHW-1:0]);

  always_comb begin
    ev_mul     = op_valid && (op == OP_MULS || op == OP_MULU);
    ev_xr_put  = op_valid && (op == OP_XR_PUT);
    ev_xr_get  = op_valid && (op == OP_XR_GET);
    ev_sat     = op_valid && (op == OP_SAT_LO || op == OP_SAT_HI);
    ev_bittest = op_valid && (op == OP_BITTEST);
    ev_dst_wr  = ev_mul | ev_xr_get | ev_sat;
    ev_xr_wr   = ev_mul | ev_xr_put;
  end

  always_comb begin
    dst_next = '0;
    xr_next  = xr_q;
    f_next   = f_in;
    unique case (op)
      OP_MULS, OP_MULU: begin
        dst_next = product[DW-1:0];
        xr_next  = product[2*DW-1:DW];
        f_next   = result_flags(product[DW-1:0]);
      end
      OP_XR_PUT: xr_next = src_b;
      OP_XR_GET: begin
        dst_next = xr_q;
        f_next   = result_flags(xr_q);
      end
      OP_SAT_LO:  dst_next = sat_res[0];
      OP_SAT_HI:  dst_next = sat_res[1];
      OP_BITTEST: f_next.c = bit_hit;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dst_we    <= 1'b0;
      dst_data  <= '0;
      xr_q      <= '0;
      flags_out <= '0;
    end else begin
      dst_we <= ev_dst_wr;
      if (ev_dst_wr) dst_data <= dst_next;
      if (ev_xr_wr)  xr_q     <= xr_next;
      if (op_valid)  flags_out <= f_next;
    end
  end
endmodule

// File: rtl/mulx_exec_unit_chk.sv
module mulx_exec_unit_chk #(
  parameter int DW       = 32,
  parameter int SAT_W_LO = 16,
  parameter int SAT_W_HI = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [DW-1:0] src_b,
  input logic [3:0]    flags_in,
  input logic          dst_we,
  input logic [DW-1:0] dst_data,
  input logic [DW-1:0] xr_q,
  input logic [3:0]    flags_out,
  input logic          ev_mul,
  input logic          ev_xr_put,
  input logic          ev_xr_get,
  input logic          ev_sat,
  input logic          ev_bittest,
  input logic          sat_sel_hi
);
  localparam longint LO_MAX = (longint'(1) << (SAT_W_LO - 1)) - 1;
  localparam longint LO_MIN = -(longint'(1) << (SAT_W_LO - 1));
  localparam longint HI_MAX = (longint'(1) << (SAT_W_HI - 1)) - 1;
  localparam longint HI_MIN = -(longint'(1) << (SAT_W_HI - 1));

  longint dst_s;
  assign dst_s = longint'($signed(dst_data));

  a_r3_mul_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mul |=> dst_we && flags_out[3:2] == 2'b00
               && flags_out[1] == dst_data[DW-1]
               && flags_out[0] == (dst_data == '0));

  a_r5_xr_put: assert property (@(posedge clk) disable iff (!rst_n)
    ev_xr_put |=> !dst_we && xr_q == $past(src_b) && flags_out == $past(flags_in));

  a_r6_xr_get: assert property (@(posedge clk) disable iff (!rst_n)
    ev_xr_get |=> dst_we && dst_data == $past(xr_q) && xr_q == $past(xr_q)
                  && flags_out == {2'b00, dst_data[DW-1], dst_data == '0});

  a_r7_sat_lo_range: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sat && !sat_sel_hi) |=> dst_we && dst_s <= LO_MAX && dst_s >= LO_MIN
                                && flags_out == $past(flags_in));

  a_r8_sat_hi_range: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sat && sat_sel_hi) |=> dst_we && dst_s <= HI_MAX && dst_s >= HI_MIN
                               && flags_out == $past(flags_in));

  a_r9_bittest_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bittest |=> !dst_we && flags_out[3] == $past(flags_in[3])
                   && flags_out[1:0] == $past(flags_in[1:0]));

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !dst_we && xr_q == $past(xr_q) && flags_out == $past(flags_out));

  always_comb begin
    if (rst_n) a_r10_events_exclusive: assert ($onehot0({ev_mul, ev_xr_put, ev_xr_get, ev_sat, ev_bittest}));
  end
endmodule

bind mulx_exec_unit mulx_exec_unit_chk #(.DW(DW), .SAT_W_LO(SAT_W_LO), .SAT_W_HI(SAT_W_HI)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .src_b      (src_b),
  .flags_in   (flags_in),
  .dst_we     (dst_we),
  .dst_data   (dst_data),
  .xr_q       (xr_q),
  .flags_out  (flags_out),
  .ev_mul     (ev_mul),
  .ev_xr_put  (ev_xr_put),
  .ev_xr_get  (ev_xr_get),
  .ev_sat     (ev_sat),
  .ev_bittest (ev_bittest),
  .sat_sel_hi (op_code[0])
);

// File: tb/mulx_exec_unit_test.sv
module mulx_exec_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = 3'd7;
  logic [31:0] src_a = '0, src_b = '0;
  logic [1:0]  imm_sel = '0;
  logic [15:0] imm_hi = '0, imm_lo = '0;
  logic [3:0]  flags_in = '0;
  logic        dst_we;
  logic [31:0] dst_data, xr_q;
  logic [3:0]  flags_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  mulx_exec_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .src_a(src_a), .src_b(src_b), .imm_sel(imm_sel), .imm_hi(imm_hi),
    .imm_lo(imm_lo), .flags_in(flags_in), .dst_we(dst_we),
    .dst_data(dst_data), .xr_q(xr_q), .flags_out(flags_out)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Present one operation for one edge, then sample a moment after that edge.
  task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [1:0] isel, input logic [15:0] ih, input logic [15:0] il,
                       input logic [3:0] fin);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; src_a = a; src_b = b;
    imm_sel = isel; imm_hi = ih; imm_lo = il; flags_in = fin;
    @(posedge clk);
    #1;
    op_valid = 1'b0;
  endtask

  function automatic logic [63:0] ref_product(input logic [31:0] a, input logic [31:0] b, input bit sgn);
    if (sgn) return 64'(longint'($signed(a)) * longint'($signed(b)));
    return {32'b0, a} * {32'b0, b};
  endfunction

  function automatic logic [3:0] ref_zn(input logic [31:0] r);
    return {2'b00, r[31], r == 32'b0};
  endfunction

  function automatic logic [31:0] ref_clamp(input logic [31:0] v, input int bits);
    longint lim_hi = (longint'(1) <<< (bits - 1)) - 1;
    longint lim_lo = -(longint'(1) <<< (bits - 1));
    longint sv = longint'($signed(v));
    if (sv > lim_hi) return 32'(lim_hi);
    if (sv < lim_lo) return 32'(lim_lo);
    return v;
  endfunction

  task automatic t_reset;
    chk("R11 dst_we", 64'(dst_we), 64'd0);
    chk("R11 dst_data", 64'(dst_data), 64'd0);
    chk("R11 xr_q", 64'(xr_q), 64'd0);
    chk("R11 flags_out", 64'(flags_out), 64'd0);
  endtask

  task automatic t_mul(input string req, input bit sgn, input logic [31:0] a, input logic [31:0] b,
                       input logic [1:0] isel, input logic [15:0] ih, input logic [15:0] il,
                       input logic [31:0] opnd, input logic [63:0] exp_prod);
    logic [63:0] p;
    p = ref_product(a, opnd, sgn);
    chk({req, " model"}, p, exp_prod);
    issue(sgn ? 3'd0 : 3'd1, a, b, isel, ih, il, 4'b1100);
    // R10: low and high word land on the same edge.
    chk({req, " R10 dst_we"}, 64'(dst_we), 64'd1);
    chk({req, " low word"}, 64'(dst_data), 64'(exp_prod[31:0]));
    chk({req, " high word"}, 64'(xr_q), 64'(exp_prod[63:32]));
    chk({req, " R3 flags"}, 64'(flags_out), 64'(ref_zn(exp_prod[31:0])));
  endtask

  task automatic t_xr_put(input logic [31:0] v, input logic [3:0] fin);
    issue(3'd2, 32'h0, v, 2'd0, 16'h0, 16'h0, fin);
    chk("R5 xr_q", 64'(xr_q), 64'(v));
    chk("R5 dst_we", 64'(dst_we), 64'd0);
    chk("R5 flags", 64'(flags_out), 64'(fin));
  endtask

  task automatic t_xr_get(input logic [31:0] v, input logic [3:0] exp_f);
    issue(3'd3, 32'h0, 32'hDEAD_BEEF, 2'd0, 16'h0, 16'h0, 4'b1111);
    chk("R6 dst_we", 64'(dst_we), 64'd1);
    chk("R6 dst_data", 64'(dst_data), 64'(v));
    chk("R6 flags", 64'(flags_out), 64'(exp_f));
  endtask

  task automatic t_sat(input bit hi, input logic [31:0] v, input logic [31:0] exp_v);
    string req = hi ? "R8" : "R7";
    chk({req, " model"}, 64'(ref_clamp(v, hi ? 24 : 16)), 64'(exp_v));
    issue(hi ? 3'd5 : 3'd4, 32'h0, v, 2'd0, 16'h0, 16'h0, 4'b1010);
    chk({req, " dst_data"}, 64'(dst_data), 64'(exp_v));
    chk({req, " flags"}, 64'(flags_out), 64'b1010);
  endtask

  task automatic t_bittest(input logic [31:0] amt, input logic [31:0] v, input logic [3:0] fin,
                           input bit exp_c);
    issue(3'd6, amt, v, 2'd0, 16'h0, 16'h0, fin);
    chk("R9 dst_we", 64'(dst_we), 64'd0);
    chk("R9 flags", 64'(flags_out), 64'({fin[3], exp_c, fin[1:0]}));
  endtask

  task automatic t_idle;
    logic [31:0] xr_before;
    logic [3:0]  f_before;
    xr_before = xr_q;
    f_before  = flags_out;
    @(negedge clk);
    op_code = 3'd0; src_a = 32'h7; src_b = 32'h9; flags_in = 4'b0101;
    repeat (2) @(posedge clk);
    #1;
    chk("R10 idle dst_we", 64'(dst_we), 64'd0);
    chk("R10 idle xr_q", 64'(xr_q), 64'(xr_before));
    chk("R10 idle flags", 64'(flags_out), 64'(f_before));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;

    // R1: -3 * 7, flags_in C,V set must be cleared (R3)
    t_mul("R1 signed", 1'b1, 32'hFFFF_FFFD, 32'd7, 2'd0, 16'h0, 16'h0, 32'd7, 64'hFFFF_FFFF_FFFF_FFEB);
    t_mul("R1 zero low", 1'b1, 32'h0001_0000, 32'h0001_0000, 2'd0, 16'h0, 16'h0, 32'h0001_0000, 64'h0000_0001_0000_0000);
    // R2: unsigned operands
    t_mul("R2 unsigned", 1'b0, 32'hFFFF_FFFF, 32'd2, 2'd0, 16'h0, 16'h0, 32'd2, 64'h0000_0001_FFFF_FFFE);
    // R4: immediate forms
    t_mul("R4 imm8 signed", 1'b1, 32'd2, 32'hAAAA_AAAA, 2'd1, 16'h0080, 16'h0, 32'hFFFF_FF80, 64'hFFFF_FFFF_FFFF_FF00);
    t_mul("R4 imm8 unsigned", 1'b0, 32'd2, 32'h0, 2'd1, 16'h00FF, 16'h0, 32'hFFFF_FFFF, 64'h0000_0001_FFFF_FFFE);
    t_mul("R4 imm16", 1'b1, 32'd1, 32'h0, 2'd2, 16'h8000, 16'h0, 32'hFFFF_8000, 64'hFFFF_FFFF_FFFF_8000);
    t_mul("R4 imm32", 1'b1, 32'd1, 32'h0, 2'd3, 16'h1234, 16'h5678, 32'h1234_5678, 64'h0000_0000_1234_5678);

    t_xr_put(32'hCAFE_F00D, 4'b0101);
    t_xr_get(32'hCAFE_F00D, 4'b0010);
    t_idle();
    t_xr_put(32'h0, 4'b0010);
    t_xr_get(32'h0, 4'b0001);

    t_sat(1'b0, 32'h0001_2345, 32'h0000_7FFF);
    t_sat(1'b0, 32'hFFFE_7960, 32'hFFFF_8000);
    t_sat(1'b0, 32'h0000_04D2, 32'h0000_04D2);
    t_sat(1'b0, 32'hFFFF_8000, 32'hFFFF_8000);
    t_sat(1'b1, 32'h7FFF_FFFF, 32'h007F_FFFF);
    t_sat(1'b1, 32'h8000_0000, 32'hFF80_0000);
    t_sat(1'b1, 32'hFF80_0000, 32'hFF80_0000);
    t_sat(1'b1, 32'h0080_0000, 32'h007F_FFFF);

    t_bittest(32'd31, 32'h0000_0001, 4'b1011, 1'b1);
    t_bittest(32'd31, 32'h0000_0002, 4'b0111, 1'b0);
    t_bittest(32'h0000_0021, 32'h8000_0000, 4'b0100, 1'b0);
    t_bittest(32'h0000_0020, 32'h8000_0000, 4'b0000, 1'b1);
    t_idle();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule